// File: doc/BRIEF.md
# Time-Slot Bus Arbiter with Round-Robin Fallback

This block arbitrates one shared on-chip interconnect among several initiators (four by default). Time is cut into slots, and sixteen consecutive slots form a repeating frame. A slot table, written through a small configuration port, can reserve any slot for one initiator so that a time-critical link gets a guaranteed share of the bus. A reserved slot goes to its owner whenever the owner asks for it. If the owner is silent, it has in effect turned the slot down, and the slot is handed to the other requesters in round-robin order. Unreserved slots are contention slots and are always settled by round-robin.

Each slot yields at most one grant. The grant is decided in the last cycle of the previous slot and then held for the whole slot. A programmable latency of 2 to 7 bus cycles separates the appearance of the grant from the single data cycle, which a grant-valid strobe marks. That data cycle closes the slot, so one slot lasts latency plus one cycles. The index of the slot now being served is an output.

Top module: `tdma_arb`

## Requirements
- R1: During and just after reset, grant is all zeros, grantValid is low and slotIdx is 0. Reset also sets every table entry to unowned, the latency to 2 and the round-robin pointer to initiator 0.
- R2: grant has at most one bit set, and it stays unchanged for every cycle of a slot.
- R3: When the current slot's table entry is valid and its owner (entry owner field, initiator index) is requesting in the decision cycle, the owner is granted, whatever the other requests are.
- R4: When a valid entry's owner is not requesting, the slot goes to the other requesters by round-robin.
- R5: A slot whose entry is invalid is granted by round-robin among all requesters, searching upward from the pointer and wrapping from the highest index to 0.
- R6: A round-robin grant moves the pointer to the index just past the winner, wrapping to 0. An owner grant, or a slot with no grant, leaves the pointer unchanged.
- R7: If no request line is high in the decision cycle, the slot has an all-zero grant and grantValid stays low for the whole slot.
- R8: The decision samples req in the last cycle of the previous slot (for slot 0, the first cycle after reset). grant appears in the next cycle, and grantValid is high for exactly one cycle, L cycles later, where L is the latency. A slot therefore spans L+1 cycles.
- R9: slotIdx rises by one at each slot start and wraps from 15 to 0.
- R10: Table and latency writes act from the next slot decision. A write made during a decision cycle is not used by that decision.
- R11: A written latency below 2 is stored as 2, and one above 7 is stored as 7.
- R12: Writing an entry with cfgSlotValid low makes that slot unowned, whatever owner field is supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| req | input | NUM_INIT (4) | Request line per initiator |
| cfgSlotWe | input | 1 | Slot table write strobe |
| cfgSlotIdx | input | SLOT_W (4) | Table entry to write |
| cfgSlotOwner | input | INIT_W (2) | Owner initiator index for the entry |
| cfgSlotValid | input | 1 | 1 = slot owned, 0 = unowned |
| cfgLatWe | input | 1 | Latency write strobe |
| cfgLatVal | input | LAT_CFG_W (4) | Requested latency in cycles, clamped to 2..7 |
| grant | output | NUM_INIT (4) | One-hot grant for the current slot |
| grantValid | output | 1 | Data cycle of the granted slot |
| slotIdx | output | SLOT_W (4) | Index of the slot being served |

## Verification
The cycle that closes a slot carries two jobs at once: it is the data cycle of the current grant and the decision cycle of the next slot. A configuration write can land in that same cycle. The bench writes a table entry exactly in a decision cycle and checks that the decision still follows the old entry, while the slot's next use in the following frame follows the new one. It also changes the latency in the middle of a slot and measures the grantValid spacing of the current and the next slots to confirm that the switch happens only at the boundary.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

  // Strobes from the slot sequencer to the arbitration datapath.
  typedef struct packed {
    logic boundary;   // last cycle of a slot (or first cycle after reset): decide next slot
    logic dataPhase;  // data cycle of the slot being served
  } slotStrobes_t;

  function automatic int unsigned idxWidth(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdma_arb_ctrl.sv
module tdma_arb_ctrl
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned LAT_MIN   = 2,
  parameter int unsigned LAT_MAX   = 7,
  parameter int unsigned LAT_RESET = 2,
  parameter int unsigned LAT_CFG_W = 4,
  localparam int unsigned SLOT_W   = idxWidth(NUM_SLOTS),
  localparam int unsigned LAT_W    = idxWidth(LAT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLatWe,
  input  logic [LAT_CFG_W-1:0] cfgLatVal,
  output slotStrobes_t         strb,
  output logic [SLOT_W-1:0]    slotIdx,
  output logic [SLOT_W-1:0]    nextSlot
);

  logic              started;
  logic [LAT_W-1:0]  phase;
  logic [LAT_W-1:0]  curLat;
  logic [LAT_W-1:0]  latReg;
  logic [LAT_W-1:0]  latClamped;
  logic [SLOT_W-1:0] slotQ;
  logic              lastPhase;

  always_comb begin
    if (cfgLatVal < LAT_CFG_W'(LAT_MIN))      latClamped = LAT_W'(LAT_MIN);
    else if (cfgLatVal > LAT_CFG_W'(LAT_MAX)) latClamped = LAT_W'(LAT_MAX);
    else                                      latClamped = LAT_W'(cfgLatVal);
  end

  assign lastPhase      = (phase == curLat);
  assign strb.boundary  = !started || lastPhase;
  assign strb.dataPhase = started && lastPhase;

  always_comb begin
    if (!started)                            nextSlot = slotQ;
    else if (slotQ == SLOT_W'(NUM_SLOTS-1))  nextSlot = '0;
    else                                     nextSlot = slotQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg <= LAT_W'(LAT_RESET);
    end else if (cfgLatWe) begin
      latReg <= latClamped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started <= 1'b0;
      phase   <= '0;
      curLat  <= LAT_W'(LAT_RESET);
      slotQ   <= '0;
    end else if (strb.boundary) begin
      started <= 1'b1;
      phase   <= '0;
      curLat  <= latReg;
      slotQ   <= nextSlot;
    end else begin
      phase   <= phase + 1'b1;
    end
  end

  assign slotIdx = slotQ;

endmodule

// File: rtl/tdma_arb_dp.sv
module tdma_arb_dp
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_INIT  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned INIT_W   = idxWidth(NUM_INIT),
  localparam int unsigned SLOT_W   = idxWidth(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INIT-1:0] req,
  input  logic                cfgSlotWe,
  input  logic [SLOT_W-1:0]   cfgSlotIdx,
  input  logic [INIT_W-1:0]   cfgSlotOwner,
  input  logic                cfgSlotValid,
  input  slotStrobes_t        strb,
  input  logic [SLOT_W-1:0]   nextSlot,
  output logic [NUM_INIT-1:0] grant,
  output logic                grantValid
);

  logic [NUM_SLOTS-1:0] tblValid;
  logic [INIT_W-1:0]    tblOwner [NUM_SLOTS];

  // One register pair per slot entry.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblValid[s] <= 1'b0;
        tblOwner[s] <= '0;
      end else if (cfgSlotWe && (cfgSlotIdx == SLOT_W'(s))) begin
        tblValid[s] <= cfgSlotValid;
        tblOwner[s] <= cfgSlotOwner;
      end
    end
  end

  logic [INIT_W-1:0]   owner;
  logic                ownerReq;
  logic [INIT_W-1:0]   rrPtr;
  logic [INIT_W-1:0]   rrIdx;
  logic                rrFound;
  logic [NUM_INIT-1:0] grantNext;
  logic [NUM_INIT-1:0] grantQ;

  assign owner    = tblOwner[nextSlot];
  assign ownerReq = tblValid[nextSlot] && req[owner];

  // Round-robin search upward from the pointer, wrapping at NUM_INIT.
  always_comb begin
    int cand;
    rrFound = 1'b0;
    rrIdx   = '0;
    for (int k = 0; k < NUM_INIT; k++) begin
      cand = int'(rrPtr) + k;
      if (cand >= NUM_INIT) cand = cand - NUM_INIT;
      if (!rrFound && req[cand]) begin
        rrFound = 1'b1;
        rrIdx   = INIT_W'(cand);
      end
    end
  end

  always_comb begin
    grantNext = '0;
    if (ownerReq)     grantNext[owner] = 1'b1;
    else if (rrFound) grantNext[rrIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= '0;
      rrPtr  <= '0;
    end else if (strb.boundary) begin
      grantQ <= grantNext;
      if (!ownerReq && rrFound) begin
        rrPtr <= (rrIdx == INIT_W'(NUM_INIT-1)) ? '0 : rrIdx + 1'b1;
      end
    end
  end

  assign grant      = grantQ;
  assign grantValid = strb.dataPhase && (grantQ != '0);

endmodule

// File: rtl/tdma_arb.sv
module tdma_arb
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_INIT  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned LAT_MIN   = 2,
  parameter int unsigned LAT_MAX   = 7,
  parameter int unsigned LAT_RESET = 2,
  parameter int unsigned LAT_CFG_W = 4,
  localparam int unsigned INIT_W   = idxWidth(NUM_INIT),
  localparam int unsigned SLOT_W   = idxWidth(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_INIT-1:0]  req,
  input  logic                 cfgSlotWe,
  input  logic [SLOT_W-1:0]    cfgSlotIdx,
  input  logic [INIT_W-1:0]    cfgSlotOwner,
  input  logic                 cfgSlotValid,
  input  logic                 cfgLatWe,
  input  logic [LAT_CFG_W-1:0] cfgLatVal,
  output logic [NUM_INIT-1:0]  grant,
  output logic                 grantValid,
  output logic [SLOT_W-1:0]    slotIdx
);

  slotStrobes_t      strb;
  logic [SLOT_W-1:0] nextSlot;

  tdma_arb_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX),
    .LAT_RESET(LAT_RESET), .LAT_CFG_W(LAT_CFG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLatWe(cfgLatWe), .cfgLatVal(cfgLatVal),
    .strb(strb), .slotIdx(slotIdx), .nextSlot(nextSlot)
  );

  tdma_arb_dp #(
    .NUM_INIT(NUM_INIT), .NUM_SLOTS(NUM_SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .req(req),
    .cfgSlotWe(cfgSlotWe), .cfgSlotIdx(cfgSlotIdx),
    .cfgSlotOwner(cfgSlotOwner), .cfgSlotValid(cfgSlotValid),
    .strb(strb), .nextSlot(nextSlot),
    .grant(grant), .grantValid(grantValid)
  );

endmodule

// File: rtl/tdma_arb_chk.sv
module tdma_arb_chk
  import tdma_arb_pkg::*;
#(
  parameter int unsigned NUM_INIT  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned SLOT_W    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_INIT-1:0] req,
  input logic [NUM_INIT-1:0] grant,
  input logic                grantValid,
  input logic [SLOT_W-1:0]   slotIdx,
  input slotStrobes_t        strb
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R2
  grant_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.boundary |=> $stable(grant));

  // R8
  valid_has_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grant != '0));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);

  // R9
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> (slotIdx == (($past(slotIdx) == SLOT_W'(NUM_SLOTS-1)) ?
                                SLOT_W'(0) : SLOT_W'($past(slotIdx) + 1'b1))));

  // R7
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.boundary && (req == '0)) |=> (grant == '0));

  // R3
  granted_was_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.boundary |=> ((grant & ~$past(req)) == '0));

endmodule

bind tdma_arb tdma_arb_chk #(
  .NUM_INIT(NUM_INIT), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .grant(grant),
  .grantValid(grantValid), .slotIdx(slotIdx), .strb(strb)
);

// File: tb/test_tdma_arb.sv
`timescale 1ns/1ps
module test_tdma_arb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] req;
  logic       cfgSlotWe;
  logic [3:0] cfgSlotIdx;
  logic [1:0] cfgSlotOwner;
  logic       cfgSlotValid;
  logic       cfgLatWe;
  logic [3:0] cfgLatVal;
  logic [3:0] grant;
  logic       grantValid;
  logic [3:0] slotIdx;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  tdma_arb i_tdma_arb (
    .clk(clk), .rstN(rstN), .req(req),
    .cfgSlotWe(cfgSlotWe), .cfgSlotIdx(cfgSlotIdx),
    .cfgSlotOwner(cfgSlotOwner), .cfgSlotValid(cfgSlotValid),
    .cfgLatWe(cfgLatWe), .cfgLatVal(cfgLatVal),
    .grant(grant), .grantValid(grantValid), .slotIdx(slotIdx)
  );

  // Cycles since reset release; at the negedge of cycle i, cyc == i.
  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, actual, expected);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; req = '0;
    cfgSlotWe = 1'b0; cfgSlotIdx = '0; cfgSlotOwner = '0; cfgSlotValid = 1'b0;
    cfgLatWe = 1'b0; cfgLatVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setSlot(input int idx, input int own, input bit vld);
    cfgSlotWe = 1'b1; cfgSlotIdx = 4'(idx); cfgSlotOwner = 2'(own); cfgSlotValid = vld;
  endtask

  // Reset state, idle slots, default latency of 2.
  task automatic testResetIdle();
    doReset();
    check("R1 grant after reset", grant, 0);
    check("R1 grantValid after reset", grantValid, 0);
    check("R1 slotIdx after reset", slotIdx, 0);
    waitCyc(1);
    check("R7 idle slot0 grant", grant, 0);
    waitCyc(3);
    check("R7 idle slot0 grantValid", grantValid, 0);
    waitCyc(4);
    check("R9 slotIdx advance", slotIdx, 1);
    waitCyc(6); req = 4'b0010;
    waitCyc(7);
    check("R8 grant next cycle", grant, 4'b0010);
    check("R8 valid not early", grantValid, 0);
    check("R9 slotIdx 2", slotIdx, 2);
    waitCyc(8);
    check("R1 default latency gap", grantValid, 0);
    waitCyc(9);
    check("R8 valid after 2", grantValid, 1);
    check("R2 grant held", grant, 4'b0010);
    req = '0;
    waitCyc(10);
    check("R7 no requester grant", grant, 0);
    waitCyc(12);
    check("R7 no requester valid", grantValid, 0);
  endtask

  // Owner priority, pointer untouched by owner grant.
  task automatic testOwner();
    doReset();
    setSlot(1, 2, 1'b1);
    waitCyc(1); cfgSlotWe = 1'b0;
    waitCyc(3); req = 4'b1111;
    waitCyc(4);
    check("R3 owner wins", grant, 4'b0100);
    waitCyc(5);
    check("R2 owner grant held", grant, 4'b0100);
    waitCyc(6);
    check("R8 owner valid", grantValid, 1);
    waitCyc(7);
    check("R6 pointer kept after owner grant", grant, 4'b0001);
    waitCyc(10);
    check("R5 rr next", grant, 4'b0010);
  endtask

  // Owner refusal and round-robin rotation with wrap.
  task automatic testRefusal();
    doReset();
    setSlot(1, 2, 1'b1);
    waitCyc(1); cfgSlotWe = 1'b0;
    waitCyc(3); req = 4'b1011;
    waitCyc(4);
    check("R4 refused slot to rr", grant, 4'b0001);
    waitCyc(7);
    check("R6 pointer past winner", grant, 4'b0010);
    waitCyc(9); req = 4'b1001;
    waitCyc(10);
    check("R5 rr skips idle", grant, 4'b1000);
    waitCyc(13);
    check("R6 pointer wraps", grant, 4'b0001);
  endtask

  // Slot counter wrap.
  task automatic testWrap();
    doReset();
    waitCyc(46);
    check("R9 slot 15", slotIdx, 15);
    waitCyc(49);
    check("R9 wrap to 0", slotIdx, 0);
  endtask

  // Latency clamp and change only at a boundary.
  task automatic testLatency();
    doReset();
    req = 4'b0001;
    waitCyc(1); cfgLatWe = 1'b1; cfgLatVal = 4'd9;
    waitCyc(2); cfgLatWe = 1'b0;
    waitCyc(3);
    check("R10 old latency in running slot", grantValid, 1);
    waitCyc(10);
    check("R11 clamp high gap", grantValid, 0);
    waitCyc(11);
    check("R11 clamp high to 7", grantValid, 1);
    check("R9 slot 1 long", slotIdx, 1);
    waitCyc(12); cfgLatWe = 1'b1; cfgLatVal = 4'd0;
    waitCyc(13); cfgLatWe = 1'b0;
    waitCyc(14);
    check("R10 midslot write ignored", grantValid, 0);
    waitCyc(19);
    check("R10 slot keeps latency 7", grantValid, 1);
    waitCyc(21);
    check("R11 clamp low gap", grantValid, 0);
    waitCyc(22);
    check("R11 clamp low to 2", grantValid, 1);
    check("R9 slot 3", slotIdx, 3);
  endtask

  // Table write in a decision cycle; invalid entry means unowned.
  task automatic testTableTiming();
    doReset();
    setSlot(2, 3, 1'b1);
    waitCyc(1); setSlot(2, 3, 1'b0);
    waitCyc(2); cfgSlotWe = 1'b0;
    waitCyc(3); setSlot(1, 3, 1'b1); req = 4'b1111;
    waitCyc(4); cfgSlotWe = 1'b0;
    check("R10 write in decision cycle unused", grant, 4'b0001);
    waitCyc(7);
    check("R12 cleared entry unowned", grant, 4'b0010);
    waitCyc(52);
    check("R10 new owner next frame", grant, 4'b1000);
    check("R9 slot 1 again", slotIdx, 1);
  endtask

  initial begin
    rstN = 1'b0;
    testResetIdle();
    testOwner();
    testRefusal();
    testWrap();
    testLatency();
    testTableTiming();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule